// File: doc/BRIEF.md
# Predicated Byte-Group Load with Vector Broadcast

This unit fetches one 256-bit group of 32 consecutive bytes from memory under a per-byte enable mask and then broadcasts that group across a destination vector whose width is set at run time. A caller supplies a 64-bit base, a 64-bit index, a flag saying the base is the stack pointer, the register field that named the index, the enable mask and the vector length in bits. The unit then walks the enabled lanes one at a time through a single-beat request/response memory port. Disabled lanes cost no memory cycle and read back as zero.

Before any access the unit screens the operation. A vector length that is not 256, 512, 1024 or 2048 bits is refused with an undefined-operation flag, and so is an index field of all ones. When the base is the stack pointer, a nonzero low nibble raises an alignment fault. This alignment check always runs if any lane is enabled. If no lane is enabled, a configuration input decides whether it runs. A refused or faulted operation performs no read and leaves the vector at zero.

The controller has four states. IDLE waits for `start`. ISSUE picks the lowest remaining enabled lane and raises a request. WAIT holds until the response arrives. DONE pulses `done` for one cycle. The transitions are:

- IDLE→ISSUE on an accepted legal start.
- IDLE→DONE on a refused or faulted start.
- ISSUE→WAIT when a lane is left.
- ISSUE→DONE when no lane is left.
- WAIT→ISSUE on `mem_rvalid`.
- DONE→IDLE unconditionally.

Top module: `lrep_unit`

## Requirements
- R1: Lane l (0..31) reads byte address base_addr + index + l, with all arithmetic modulo 2^64.
- R2: A lane whose mask bit is 0 issues no memory request, and its byte of the 256-bit group is 0. An enabled lane's byte is the `mem_rdata` returned for its request.
- R3: Only `pred[31:0]` affect the operation. Bits 32 and above have no effect on requests, result or flags.
- R4: `vec_out` holds the 256-bit group in every 256-bit slice below `vl_bits`, and is 0 at and above `vl_bits`. Lane l sits at bits [8l+7:8l] of each slice.
- R5: If `vl_bits` is not one of 256, 512, 1024 or 2048, `undef_err` is set, no request is made and `vec_out` is 0.
- R6: If `idx_field` equals 5'b11111, `undef_err` is set, no request is made and `vec_out` is 0.
- R7: With `base_is_sp`=1, at least one enabled lane and `base_addr[3:0]` != 0, `align_fault` is set, no request is made and `vec_out` is 0. Undefined-operation refusal takes precedence and suppresses this fault.
- R8: With no enabled lane and `base_is_sp`=1, the alignment fault of R7 arises only when `sp_chk_empty`=1. Otherwise the operation completes with a zero vector.
- R9: `start` is accepted only in IDLE. `busy` is high from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse. At most one request is outstanding, and a `start` raised while busy is ignored.
- R10: The requests of one operation are issued in ascending lane order, and their number equals the count of set bits in `pred[31:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken in IDLE only) |
| base_addr | input | 64 | Base byte address |
| index | input | 64 | Byte index added to the base |
| base_is_sp | input | 1 | Base comes from the stack pointer |
| idx_field | input | 5 | Register field that named the index |
| pred | input | 256 | Per-byte enable mask (low 32 bits used) |
| vl_bits | input | 12 | Destination vector length in bits |
| sp_chk_empty | input | 1 | Run the stack alignment check when no lane is enabled |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 64 | Byte address of the request |
| mem_rdata | input | 8 | Returned byte |
| mem_rvalid | input | 1 | Response strobe for the outstanding request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |
| undef_err | output | 1 | Last operation refused as undefined |
| align_fault | output | 1 | Last operation aborted on stack misalignment |
| vec_out | output | 2048 | Broadcast result |

## Verification
The assertions assume that the memory returns exactly one `mem_rvalid` for each request, never unprompted and never before the cycle after the request. They also assume that the operation inputs stay steady for the cycle in which `start` is accepted. The bench memory model answers each request after a random delay of one to four cycles and never otherwise. The bench changes the operation inputs only away from the accepting edge, except in one deliberate case that raises `start` with scrambled inputs while the unit is busy.

// File: rtl/lrep_pkg.sv
package lrep_pkg;
    localparam int GROUP_W = 256;
    localparam int LANES   = 32;
    localparam int BYTE_W  = 8;
    localparam int LANE_IW = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } lrep_state_t;
endpackage

// File: rtl/lrep_lane_pick.sv
module lrep_lane_pick #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lrep_tile.sv
module lrep_tile #(
    parameter int GROUP  = 256,
    parameter int CHUNKS = 8,
    parameter int CNT_W  = 4
) (
    input  logic [GROUP-1:0]        group,
    input  logic [CNT_W-1:0]        ntiles,
    output logic [GROUP*CHUNKS-1:0] vec
);
    for (genvar k = 0; k < CHUNKS; k++) begin : g_tile
        assign vec[k*GROUP +: GROUP] = (ntiles > CNT_W'(k)) ? group : '0;
    end
endmodule

// File: rtl/lrep_unit.sv
module lrep_unit
    import lrep_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MAX_VL = 2048,
    localparam int PRED_W    = MAX_VL / BYTE_W,
    localparam int VL_W      = $clog2(MAX_VL) + 1,
    localparam int CHUNKS    = MAX_VL / GROUP_W,
    localparam int CHUNK_LOG = $clog2(CHUNKS),
    localparam int CNT_W     = VL_W - $clog2(GROUP_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [ADDR_W-1:0]    index,
    input  logic                 base_is_sp,
    input  logic [4:0]           idx_field,
    input  logic [PRED_W-1:0]    pred,
    input  logic [VL_W-1:0]      vl_bits,
    input  logic                 sp_chk_empty,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [BYTE_W-1:0]    mem_rdata,
    input  logic                 mem_rvalid,
    output logic                 busy,
    output logic                 done,
    output logic                 undef_err,
    output logic                 align_fault,
    output logic [MAX_VL-1:0]    vec_out
);
    lrep_state_t state, state_nx;

    logic [ADDR_W-1:0]  start_addr;
    logic [LANES-1:0]   mask_rem;
    logic [LANE_IW-1:0] lane_q;
    logic [GROUP_W-1:0] group_q;
    logic [CNT_W-1:0]   tiles_q;

    // Screening of a new operation
    logic vl_ok, any_lane, refuse, misalign, accept;
    always_comb begin
        vl_ok = 1'b0;
        for (int k = 0; k <= CHUNK_LOG; k++)
            if (vl_bits == VL_W'(GROUP_W << k)) vl_ok = 1'b1;
    end
    assign any_lane = |pred[LANES-1:0];
    assign refuse   = (idx_field == 5'h1f) || !vl_ok;
    assign misalign = base_is_sp && (any_lane || sp_chk_empty) && (base_addr[3:0] != 4'h0);
    assign accept   = start && (state == ST_IDLE);

    logic               pick_any;
    logic [LANE_IW-1:0] pick_idx;
    lrep_lane_pick #(.N(LANES)) u_pick (
        .mask (mask_rem),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = (refuse || misalign) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: state_nx = pick_any ? ST_WAIT : ST_DONE;
            ST_WAIT:  if (mem_rvalid) state_nx = ST_ISSUE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        mem_req = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:  busy    = 1'b0;
            ST_ISSUE: mem_req = pick_any;
            ST_WAIT:  ;
            ST_DONE:  done    = 1'b1;
        endcase
    end
    assign mem_addr = start_addr + ADDR_W'(pick_idx);

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr  <= '0;
            mask_rem    <= '0;
            lane_q      <= '0;
            group_q     <= '0;
            tiles_q     <= '0;
            undef_err   <= 1'b0;
            align_fault <= 1'b0;
        end else begin
            if (accept) begin
                start_addr  <= base_addr + index;
                mask_rem    <= (refuse || misalign) ? '0 : pred[LANES-1:0];
                group_q     <= '0;
                tiles_q     <= vl_bits[VL_W-1 -: CNT_W];
                undef_err   <= refuse;
                align_fault <= !refuse && misalign;
            end
            if (state == ST_ISSUE && pick_any) begin
                lane_q             <= pick_idx;
                mask_rem[pick_idx] <= 1'b0;
            end
            if (state == ST_WAIT && mem_rvalid)
                group_q[lane_q*BYTE_W +: BYTE_W] <= mem_rdata;
        end
    end

    lrep_tile #(.GROUP(GROUP_W), .CHUNKS(CHUNKS), .CNT_W(CNT_W)) u_tile (
        .group  (group_q),
        .ntiles (tiles_q),
        .vec    (vec_out)
    );

    // Checks
    logic outstanding;
    always_ff @(posedge clk) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (mem_req)    outstanding <= 1'b1;
        else if (mem_rvalid) outstanding <= 1'b0;
    end

    p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outstanding);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_addr_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - start_addr) < ADDR_W'(LANES)));
    p_undef_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> !mem_req);
    p_align_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> !mem_req);
    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_err && align_fault));
endmodule

// File: tb/lrep_unit_bench.sv
module lrep_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  base_addr = '0, index = '0;
    logic         base_is_sp = 1'b0;
    logic [4:0]   idx_field = '0;
    logic [255:0] pred = '0;
    logic [11:0]  vl_bits = 12'd256;
    logic         sp_chk_empty = 1'b0;
    logic         mem_req;
    logic [63:0]  mem_addr;
    logic [7:0]   mem_rdata = '0;
    logic         mem_rvalid = 1'b0;
    logic         busy, done, undef_err, align_fault;
    logic [2047:0] vec_out;

    int n_chk = 0, n_bad = 0;

    lrep_unit u_lrep_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .index(index),
        .base_is_sp(base_is_sp), .idx_field(idx_field), .pred(pred), .vl_bits(vl_bits),
        .sp_chk_empty(sp_chk_empty), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .busy(busy), .done(done),
        .undef_err(undef_err), .align_fault(align_fault), .vec_out(vec_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ a[63:56] ^ 8'hA5;
    endfunction

    // Memory model and request checking (R1, R10)
    logic [63:0] exp_start;
    logic [31:0] exp_mask;
    int          nxt_lane = 0, req_cnt = 0, addr_err = 0;
    logic        pend = 1'b0;
    int          dly = 0;
    logic [63:0] paddr = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_byte(paddr);
                pend       <= 1'b0;
            end else dly <= dly - 1;
        end
        if (mem_req) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            dly   <= int'($urandom % 4);
            req_cnt++;
            while (nxt_lane < 32 && !exp_mask[nxt_lane]) nxt_lane++;
            if (mem_addr - exp_start != 64'(nxt_lane)) addr_err++;
            nxt_lane++;
        end
    end

    task automatic check(input string req, input logic [2047:0] act, input logic [2047:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit vl_legal(input logic [11:0] v);
        return v == 12'd256 || v == 12'd512 || v == 12'd1024 || v == 12'd2048;
    endfunction

    task automatic run_op(input logic [63:0] b, input logic [63:0] ix, input bit sp,
                          input logic [4:0] fld, input logic [255:0] p, input logic [11:0] vl,
                          input bit chk_empty, input bit disturb);
        logic [255:0]  grp;
        logic [2047:0] exp_vec;
        bit            ex_undef, ex_align;
        int            cyc, pop;
        pop      = $countones(p[31:0]);
        ex_undef = (fld == 5'h1f) || !vl_legal(vl);
        ex_align = !ex_undef && sp && (pop > 0 || chk_empty) && (b[3:0] != 0);
        grp = '0;
        for (int l = 0; l < 32; l++)
            if (p[l]) grp[l*8 +: 8] = mem_byte(b + ix + 64'(l));
        exp_vec = '0;
        if (!ex_undef && !ex_align)
            for (int k = 0; k < 8; k++)
                if (k < int'(vl) / 256) exp_vec[k*256 +: 256] = grp;
        exp_start = b + ix; exp_mask = p[31:0]; nxt_lane = 0; req_cnt = 0; addr_err = 0;
        base_addr = b; index = ix; base_is_sp = sp; idx_field = fld; pred = p;
        vl_bits = vl; sp_chk_empty = chk_empty;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            if (disturb && cyc == 0) begin
                start = 1'b1; base_addr = ~b; pred = ~p; vl_bits = 12'd100;
            end else begin
                start = 1'b0; base_addr = b; pred = p; vl_bits = vl;
            end
            check("R9 busy during op", 2048'(busy), 2048'(1));
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; base_addr = b; pred = p; vl_bits = vl;
        check("R9 done seen", 2048'(done), 2048'(1));
        check("R2 R3 R4 vector", vec_out, exp_vec);
        check("R5 R6 undef flag", 2048'(undef_err), 2048'(ex_undef));
        check("R7 R8 align flag", 2048'(align_fault), 2048'(ex_align));
        check("R10 request count", 2048'(req_cnt), 2048'((ex_undef || ex_align) ? 0 : pop));
        check("R1 R10 address order", 2048'(addr_err), 2048'(0));
        @(negedge clk);
        check("R9 done one cycle", 2048'(done), 2048'(0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] vls [7];
        void'($urandom(32'd7331));
        vls = '{12'd256, 12'd512, 12'd1024, 12'd2048, 12'd128, 12'd768, 12'd0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset busy", 2048'(busy), 2048'(0));
        check("R9 reset done", 2048'(done), 2048'(0));
        check("R4 reset vector", vec_out, '0);
        // Directed corner cases
        run_op(64'h1000, 64'h20, 0, 5'd3, {224'h0, 32'hFFFF_FFFF}, 12'd2048, 0, 0); // R4 full
        run_op(64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 0, 5'd1, {224'h0, 32'h8000_0101}, 12'd512, 0, 0); // R1 wrap
        run_op(64'h40, 64'h0, 0, 5'd2, {224'hFFFF, 32'h0000_0000}, 12'd256, 0, 0); // R3 high bits
        run_op(64'h40, 64'h0, 0, 5'd2, {224'h0, 32'h0F0F_0000}, 12'd128, 0, 0);    // R5
        run_op(64'h40, 64'h0, 0, 5'h1f, {224'h0, 32'h1}, 12'd256, 0, 0);          // R6
        run_op(64'h48, 64'h0, 1, 5'd2, {224'h0, 32'h10}, 12'd256, 0, 0);          // R7
        run_op(64'h48, 64'h0, 1, 5'h1f, {224'h0, 32'h10}, 12'd256, 0, 0);         // R7 precedence
        run_op(64'h48, 64'h0, 1, 5'd2, 256'h0, 12'd256, 0, 0);                    // R8 no check
        run_op(64'h48, 64'h0, 1, 5'd2, 256'h0, 12'd256, 1, 0);                    // R8 check
        run_op(64'h80, 64'h3, 1, 5'd4, {224'h0, 32'hA5A5_0001}, 12'd1024, 1, 1);  // R9 start ignored
        // Constrained random
        for (int i = 0; i < 60; i++) begin
            logic [63:0]  b;
            logic [255:0] p;
            logic [4:0]   f;
            int           sel;
            b = {$urandom, $urandom};
            if ($urandom % 2) b[3:0] = 4'h0;
            p = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            sel = int'($urandom % 4);
            if (sel == 0) p[31:0] = '0;
            else if (sel == 1) p[31:0] = p[31:0] & {$urandom} & {$urandom};
            f = 5'($urandom);
            if (f == 5'h1f && ($urandom % 3) != 0) f = 5'h0;
            run_op(b, {$urandom, $urandom}, 1'($urandom), f, p,
                   (($urandom % 5) == 0) ? vls[4 + $urandom % 3] : vls[$urandom % 4],
                   1'($urandom), 1'(($urandom % 6) == 0));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule